// File: doc/BRIEF.md
# Single-Accumulator Multicycle Processor Core

This core runs a small one-operand instruction set against an external memory. There is only one data register, the accumulator. It is the hidden source and the hidden destination of every operation. Each instruction is read from memory and then decoded. If it names an operand, the operand is then fetched from memory or written to it. The accumulator is updated last.

Every micro-step has a fixed cost in clock cycles. As a result, each instruction kind takes a known, fixed number of cycles. The memory handshake is a fixed-length strobe: a read or write strobe stays high for the full access time, and the address holds steady throughout. The core stops for good when it meets the stop instruction. Only a reset starts it again.

Top module: `acc_cpu_core`

## Requirements
- R1: An instruction word carries the opcode in bits 15:12 and a byte operand address in bits 9:0. The opcodes are load=1, store=2, add=3, subtract=4, multiply=5 and stop=15.
- R2: Fetch copies the program counter to the memory address register and reads memory into the data register. It then moves the data register into the instruction register and adds 2 to the program counter. After reset, the first fetch is from address 0.
- R3: A memory access holds `mem_rd` or `mem_wr` high for 10 consecutive cycles with `mem_addr` steady. Read data is taken in the last of those cycles. The two strobes are never high together.
- R4: Load sets the accumulator to M. Add gives accumulator + M, and subtract gives accumulator − M, both modulo 2^16. M is the word at the operand address.
- R5: Multiply keeps the low 16 bits of the accumulator × M product.
- R6: Store writes the accumulator to the operand address. It leaves the accumulator and the flags unchanged.
- R7: After load, add, subtract or multiply, the zero flag is set exactly when the accumulator is 0, and the negative flag equals accumulator bit 15. Store, stop and unknown opcodes leave both flags alone.
- R8: The step costs are: transfer 1, decode 2, add/subtract 2, multiply 5, memory access 10. This gives whole-instruction totals of load 26, add 27, subtract 27, multiply 30, store 25 and stop 14 cycles.
- R9: Stop raises `halted` 14 cycles after its fetch begins. `halted` then stays high, with no further memory strobes, until reset.
- R10: During reset the accumulator, both flags, `halted`, `mem_rd` and `mem_wr` are all 0.
- R11: An opcode not listed in R1 does nothing, costs 14 cycles, and fetch goes on with the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 10 | Byte address of the memory access |
| mem_rd | output | 1 | Read strobe, held for the whole access |
| mem_wr | output | 1 | Write strobe, held for the whole access |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid during the last strobe cycle |
| acc_out | output | 16 | Accumulator value |
| zero_flag | output | 1 | Last result was zero |
| neg_flag | output | 1 | Last result had bit 15 set |
| halted | output | 1 | Core has executed stop |

## Verification
The bench runs the seven-instruction program (X+Y)·(X−Y) over several operand pairs:
- Operands equal to each other drive the result to zero. A core that failed to update the zero flag, or updated it on store, would report the wrong flag.
- Pairs with X below Y make subtract wrap. A core with a swapped subtract operand order, or a missing modulo, would store a wrong word.
- Large operands overflow the product. A core that kept the wrong half of the product would store a wrong word.

The bench also counts cycles to `halted`. A single wrong step cost changes that count.

Other checks cover the following:
- The first fetch strobe length.
- An unknown opcode that must leave the accumulator alone.
- A halted core that must stay silent on the memory strobes.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam logic [3:0] OPC_LOAD  = 4'h1;
  localparam logic [3:0] OPC_STORE = 4'h2;
  localparam logic [3:0] OPC_ADD   = 4'h3;
  localparam logic [3:0] OPC_SUB   = 4'h4;
  localparam logic [3:0] OPC_MUL   = 4'h5;
  localparam logic [3:0] OPC_STOP  = 4'hF;

  typedef enum logic [3:0] {
    ST_FMAR,   // PC -> MAR
    ST_FREAD,  // memory -> MDR (instruction)
    ST_FIR,    // MDR -> IR, PC += 2
    ST_DECODE,
    ST_XMAR,   // IR address -> MAR
    ST_XREAD,  // memory -> MDR (operand)
    ST_XWRITE, // MDR -> memory
    ST_XALU,   // accumulator update
    ST_HALT
  } cpu_state_t;

  function automatic logic uses_operand(input logic [3:0] opc);
    return (opc == OPC_LOAD) || (opc == OPC_STORE) || (opc == OPC_ADD) ||
           (opc == OPC_SUB) || (opc == OPC_MUL);
  endfunction
endpackage

// File: rtl/acc_cpu_step_timer.sv
module acc_cpu_step_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] rst_val,
  input  logic [CW-1:0] load_val,
  output logic          step_end
);
  logic [CW-1:0] cnt_q;

  assign step_end = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= rst_val;
    else if (step_end) cnt_q <= load_val;
    else               cnt_q <= cnt_q - 1'b1;
  end

  // R8
  step_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_end |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/acc_cpu_sequencer.sv
module acc_cpu_sequencer
  import acc_cpu_pkg::*;
#(
  parameter int XFER_CYC = 1,
  parameter int DEC_CYC  = 2,
  parameter int ADD_CYC  = 2,
  parameter int MUL_CYC  = 5,
  parameter int MEM_CYC  = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] opc,
  output cpu_state_t state,
  output logic       step_end
);
  localparam int MAX_A   = (XFER_CYC > DEC_CYC) ? XFER_CYC : DEC_CYC;
  localparam int MAX_B   = (ADD_CYC > MUL_CYC) ? ADD_CYC : MUL_CYC;
  localparam int MAX_AB  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_CYC = (MAX_AB > MEM_CYC) ? MAX_AB : MEM_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);

  cpu_state_t state_q, state_d;

  function automatic logic [CW-1:0] step_cost(input cpu_state_t s, input logic [3:0] o);
    int c;
    case (s)
      ST_FREAD, ST_XREAD, ST_XWRITE: c = MEM_CYC;
      ST_DECODE:                     c = DEC_CYC;
      ST_XALU: begin
        if (o == OPC_MUL)                         c = MUL_CYC;
        else if (o == OPC_ADD || o == OPC_SUB)    c = ADD_CYC;
        else                                      c = XFER_CYC;
      end
      default:                       c = XFER_CYC;
    endcase
    return CW'(c - 1);
  endfunction

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_FMAR:   state_d = ST_FREAD;
      ST_FREAD:  state_d = ST_FIR;
      ST_FIR:    state_d = ST_DECODE;
      ST_DECODE: begin
        if (opc == OPC_STOP)       state_d = ST_HALT;
        else if (uses_operand(opc)) state_d = ST_XMAR;
        else                        state_d = ST_FMAR;
      end
      ST_XMAR:   state_d = (opc == OPC_STORE) ? ST_XWRITE : ST_XREAD;
      ST_XREAD:  state_d = ST_XALU;
      ST_XWRITE: state_d = ST_FMAR;
      ST_XALU:   state_d = ST_FMAR;
      default:   state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        state_q <= ST_FMAR;
    else if (step_end) state_q <= state_d;
  end

  acc_cpu_step_timer #(.CW(CW)) timer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_val (step_cost(ST_FMAR, 4'h0)),
    .load_val(step_cost(state_d, opc)),
    .step_end(step_end)
  );

  assign state = state_q;

  // R9
  halt_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_HALT |=> state_q == ST_HALT);
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [3:0]    opc,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] opnd,
  output logic [DW-1:0] result,
  output logic          res_zero,
  output logic          res_neg
);
  function automatic logic [DW-1:0] low_product(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [2*DW-1:0] p;
    p = a * b;
    return p[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] combine(input logic [3:0] o, input logic [DW-1:0] a,
                                            input logic [DW-1:0] m);
    case (o)
      OPC_LOAD: return m;
      OPC_ADD:  return a + m;
      OPC_SUB:  return a - m;
      OPC_MUL:  return low_product(a, m);
      default:  return a;
    endcase
  endfunction

  assign result   = combine(opc, acc, opnd);
  assign res_zero = (result == '0);
  assign res_neg  = result[DW-1];
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int DW       = 16,
  parameter int AW       = 10,
  parameter int XFER_CYC = 1,
  parameter int DEC_CYC  = 2,
  parameter int ADD_CYC  = 2,
  parameter int MUL_CYC  = 5,
  parameter int MEM_CYC  = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] acc_out,
  output logic          zero_flag,
  output logic          neg_flag,
  output logic          halted
);
  localparam int OPW    = 4;
  localparam int OPC_LO = DW - OPW;
  localparam int PC_INC = DW / 8;

  logic [AW-1:0] pc_q, mar_q;
  logic [DW-1:0] mdr_q, ir_q, acc_q;
  logic          zf_q, nf_q;
  logic [3:0]    opc;
  cpu_state_t    state;
  logic          step_end;
  logic [DW-1:0] alu_res;
  logic          alu_zero, alu_neg;
  logic          ir_load, acc_load;

  assign opc      = ir_q[DW-1:OPC_LO];
  assign ir_load  = step_end && (state == ST_FIR);
  assign acc_load = step_end && (state == ST_XALU);

  acc_cpu_sequencer #(
    .XFER_CYC(XFER_CYC), .DEC_CYC(DEC_CYC), .ADD_CYC(ADD_CYC),
    .MUL_CYC(MUL_CYC), .MEM_CYC(MEM_CYC)
  ) seq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .opc     (opc),
    .state   (state),
    .step_end(step_end)
  );

  acc_cpu_alu #(.DW(DW)) alu_i (
    .opc     (opc),
    .acc     (acc_q),
    .opnd    (mdr_q),
    .result  (alu_res),
    .res_zero(alu_zero),
    .res_neg (alu_neg)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
      acc_q <= '0;
      zf_q  <= 1'b0;
      nf_q  <= 1'b0;
    end else if (step_end) begin
      case (state)
        ST_FMAR:  mar_q <= pc_q;
        ST_FREAD: mdr_q <= mem_rdata;
        ST_FIR: begin
          ir_q <= mdr_q;
          pc_q <= pc_q + AW'(PC_INC);
        end
        ST_XMAR: begin
          mar_q <= ir_q[AW-1:0];
          if (opc == OPC_STORE) mdr_q <= acc_q;
        end
        ST_XREAD: mdr_q <= mem_rdata;
        ST_XALU: begin
          acc_q <= alu_res;
          zf_q  <= alu_zero;
          nf_q  <= alu_neg;
        end
        default: ;
      endcase
    end
  end

  assign mem_addr  = mar_q;
  assign mem_rd    = (state == ST_FREAD) || (state == ST_XREAD);
  assign mem_wr    = (state == ST_XWRITE);
  assign mem_wdata = mdr_q;
  assign acc_out   = acc_q;
  assign zero_flag = zf_q;
  assign neg_flag  = nf_q;
  assign halted    = (state == ST_HALT);

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ir_load |=> pc_q == $past(pc_q) + AW'(PC_INC));

  // R3
  no_rdwr_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !step_end) |=> (mem_rd && $stable(mem_addr)));

  // R7
  flag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_load |=> (zero_flag == (acc_out == '0)) && (neg_flag == acc_out[DW-1]));

  // R6
  store_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> $stable(acc_out) && $stable(zero_flag) && $stable(neg_flag));

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && !mem_rd && !mem_wr);
endmodule

// File: tb/acc_cpu_core_tb_top.sv
module acc_cpu_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  mem_addr;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [15:0] acc_out;
  logic        zero_flag, neg_flag, halted;
  logic [15:0] mem [0:511];
  int          total = 0;
  int          bad = 0;

  always #2.5 clk = ~clk;

  assign mem_rdata = mem[mem_addr[9:1]];

  acc_cpu_core dut_i (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .acc_out(acc_out),
    .zero_flag(zero_flag), .neg_flag(neg_flag), .halted(halted)
  );

  // operand pairs X, Y
  localparam logic [15:0] VEC [6][2] = '{
    '{16'd3, 16'd2}, '{16'd7, 16'd7}, '{16'd2, 16'd5},
    '{16'h1234, 16'h0101}, '{16'hFFFF, 16'd1}, '{16'd300, 16'd100}};

  function automatic logic [15:0] enc(input logic [3:0] op, input logic [9:0] a);
    return {op, 2'b00, a};
  endfunction

  // R8 whole-instruction cycle totals
  function automatic int icyc(input logic [3:0] op);
    int base;
    base = 1 + 10 + 1 + 2;
    case (op)
      4'h1:       return base + 1 + 10 + 1;
      4'h2:       return base + 1 + 10;
      4'h3, 4'h4: return base + 1 + 10 + 2;
      4'h5:       return base + 1 + 10 + 5;
      default:    return base;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_reset();
    rst_n = 1'b0;
    for (int i = 0; i < 512; i++) mem[i] = 16'h0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(output int cyc);
    cyc = 0;
    while (!halted && cyc < 2000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (mem_wr) mem[mem_addr[9:1]] = mem_wdata;
    end
  endtask

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc, n;
    logic [15:0] x, y, ea, ec, held;

    // R10 reset state
    start_reset();
    chk("R10 acc", acc_out, 0);
    chk("R10 flags", {zero_flag, neg_flag}, 0);
    chk("R10 halted", halted, 0);
    chk("R10 strobes", {mem_rd, mem_wr}, 0);

    // R1 R4 R5 R6 R7 R8: vector table walked by one loop
    for (int v = 0; v < 6; v++) begin
      start_reset();
      x = VEC[v][0];
      y = VEC[v][1];
      mem[0] = enc(4'h1, 10'h100);
      mem[1] = enc(4'h3, 10'h102);
      mem[2] = enc(4'h2, 10'h104);
      mem[3] = enc(4'h1, 10'h100);
      mem[4] = enc(4'h4, 10'h102);
      mem[5] = enc(4'h5, 10'h104);
      mem[6] = enc(4'h2, 10'h106);
      mem[7] = enc(4'hF, 10'h000);
      mem[9'h80] = x;
      mem[9'h81] = y;
      ec = x + y;
      ea = 16'((32'(x) * 32'(x)) - (32'(y) * 32'(y)));
      rst_n = 1'b1;
      run(cyc);
      chk("R4 stored sum", mem[9'h82], ec);
      chk("R5 stored product", mem[9'h83], ea);
      chk("R6 acc after store", acc_out, ea);
      chk("R7 zero", zero_flag, ea == 16'h0);
      chk("R7 neg", neg_flag, ea[15]);
      chk("R8 cycles", cyc, icyc(4'h1) * 2 + icyc(4'h3) + icyc(4'h4) + icyc(4'h5) +
                            icyc(4'h2) * 2 + icyc(4'hF));
    end

    // R2 R3 first fetch from address 0, strobe held 10 cycles
    start_reset();
    mem[0] = enc(4'hF, 10'h000);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R2 first fetch address", mem_addr, 0);
    n = 0;
    while (mem_rd && n < 50) begin
      n++;
      @(posedge clk);
      @(negedge clk);
    end
    chk("R3 read strobe length", n, 10);

    // R11 unknown opcode is a no-op
    start_reset();
    mem[0] = enc(4'h1, 10'h100);
    mem[1] = enc(4'h7, 10'h102);
    mem[2] = enc(4'hF, 10'h000);
    mem[9'h80] = 16'h8001;
    mem[9'h81] = 16'h0005;
    rst_n = 1'b1;
    run(cyc);
    chk("R11 acc unchanged", acc_out, 16'h8001);
    chk("R11 flags kept", {zero_flag, neg_flag}, 2'b01);
    chk("R11 cycles", cyc, icyc(4'h1) + icyc(4'h7) + icyc(4'hF));

    // R6 R7 store of zero keeps zero flag, overwrites target
    start_reset();
    mem[0] = enc(4'h1, 10'h100);
    mem[1] = enc(4'h2, 10'h108);
    mem[2] = enc(4'hF, 10'h000);
    mem[9'h84] = 16'hBEEF;
    rst_n = 1'b1;
    run(cyc);
    chk("R6 store target", mem[9'h84], 16'h0000);
    chk("R7 zero after store", {zero_flag, neg_flag}, 2'b10);
    chk("R8 store cycles", cyc, icyc(4'h1) + icyc(4'h2) + icyc(4'hF));

    // R9 halted stays, no strobes
    held = acc_out;
    n = 0;
    for (int i = 0; i < 30; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (!halted || mem_rd || mem_wr || acc_out !== held) n++;
    end
    chk("R9 halt held quiet", n, 0);

    // R9 stop alone: 14 cycles
    start_reset();
    mem[0] = enc(4'hF, 10'h000);
    rst_n = 1'b1;
    run(cyc);
    chk("R9 stop cycles", cyc, 14);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule